// File: doc/BRIEF.md
# Double-Buffered Event Flag Store

This block keeps a fixed set of events. Each event has a one-bit occurrence flag and a data value. Producers post events through an emit port that carries a slot index and a value. Posted events go into a working ("live") bank. A consumer task reads event presence and values from a second, "frozen" bank, which changes only when a task-start strobe arrives.

On the strobe, the whole live bank is copied into the frozen bank in one clock edge, and the live flags are cleared in that same edge. Every read made between two strobes therefore comes from one consistent picture. Suppose a producer posts y only after seeing x. Then a reader can never find y present while x is absent.

The event count and the value width are parameters. An emit that arrives in the same cycle as the strobe is kept for the next snapshot.

Top module: `evt_snapshot_store`

## Requirements
- R1: After reset, every frozen flag reads 0 and every frozen value reads 0. The live flags and values are also zero.
- R2: An emit changes only the live bank. `frz_flags`, `rd_flag` and `rd_val` stay unchanged until the next snapshot strobe.
- R3: When `snap_strobe` is high at a clock edge, each frozen flag and value takes the live content from before that edge. The result is visible at the read port right after that edge.
- R4: The same strobe edge clears every live flag. A second strobe with no emits in between gives all frozen flags 0.
- R5: An emit at the same edge as a strobe is not part of the snapshot being taken. It appears in the following snapshot.
- R6: When one slot is emitted several times between strobes, its flag stays set and the snapshot holds the value from the last emit.
- R7: Reading a slot whose frozen flag is 0 returns flag 0 together with the value it held at the last snapshot. Live values are not cleared, so this is the last value ever emitted to that slot, or 0 if it was never emitted.
- R8: Slot indices at or above `NUM_EVT` are outside the store. An emit to such an index is ignored. A read of such an index returns flag 0 and value 0.
- R9: Take an event x emitted at an earlier edge than an event y, with no strobe edge between the two emits. No snapshot then shows y present and x absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| emit_valid | input | 1 | Post an event this cycle |
| emit_idx | input | IDX_W | Slot index of the posted event |
| emit_val | input | VAL_W | Value carried by the posted event |
| snap_strobe | input | 1 | Task start: copy live into frozen and clear the live flags |
| rd_idx | input | IDX_W | Slot index to read from the frozen bank |
| rd_flag | output | 1 | Frozen occurrence flag of `rd_idx` |
| rd_val | output | VAL_W | Frozen value of `rd_idx` |
| frz_flags | output | NUM_EVT | All frozen flags, bit i for slot i |

## Verification
The assertions assume that `emit_valid`, `emit_idx`, `emit_val` and `snap_strobe` are steady around each rising edge, and that the strobe is a level sampled once per edge. The checks do not hold if these inputs change at the edge.

The bench changes every input only on the falling clock edge, so the design always sees settled inputs. Its random phase covers strobes and emits in the same cycle, indices beyond the last slot, and runs of several strobes in a row. All of this stays within those assumptions.

// File: rtl/evt_snap_pkg.sv
package evt_snap_pkg;
   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/evt_live_bank.sv
module evt_live_bank #(
   parameter int NUM_EVT = 6,
   parameter int VAL_W   = 16,
   parameter int IDX_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     emit_valid,
   input  logic [IDX_W-1:0]         emit_idx,
   input  logic [VAL_W-1:0]         emit_val,
   input  logic                     snap_strobe,
   output logic [NUM_EVT-1:0]       live_flags,
   output logic [NUM_EVT*VAL_W-1:0] live_vals
);
   for (genvar g = 0; g < NUM_EVT; g++) begin : g_slot
      logic hit;
      assign hit = emit_valid && (emit_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            live_flags[g]              <= 1'b0;
            live_vals[g*VAL_W +: VAL_W] <= '0;
         end else begin
            if (hit) begin
               live_flags[g]              <= 1'b1;
               live_vals[g*VAL_W +: VAL_W] <= emit_val;
            end else if (snap_strobe) begin
               live_flags[g] <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/evt_frozen_bank.sv
module evt_frozen_bank #(
   parameter int NUM_EVT = 6,
   parameter int VAL_W   = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     snap_strobe,
   input  logic [NUM_EVT-1:0]       live_flags,
   input  logic [NUM_EVT*VAL_W-1:0] live_vals,
   output logic [NUM_EVT-1:0]       frz_flags,
   output logic [NUM_EVT*VAL_W-1:0] frz_vals
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frz_flags <= '0;
         frz_vals  <= '0;
      end else if (snap_strobe) begin
         frz_flags <= live_flags;
         frz_vals  <= live_vals;
      end
   end
endmodule

// File: rtl/evt_read_port.sv
module evt_read_port #(
   parameter int NUM_EVT = 6,
   parameter int VAL_W   = 16,
   parameter int IDX_W   = 3
) (
   input  logic [IDX_W-1:0]         rd_idx,
   input  logic [NUM_EVT-1:0]       frz_flags,
   input  logic [NUM_EVT*VAL_W-1:0] frz_vals,
   output logic                     rd_flag,
   output logic [VAL_W-1:0]         rd_val
);
   always_comb begin
      rd_flag = 1'b0;
      rd_val  = '0;
      for (int i = 0; i < NUM_EVT; i++) begin
         if (rd_idx == IDX_W'(i)) begin
            rd_flag = frz_flags[i];
            rd_val  = frz_vals[i*VAL_W +: VAL_W];
         end
      end
   end
endmodule

// File: rtl/evt_snapshot_store.sv
module evt_snapshot_store #(
   parameter int NUM_EVT = 6,
   parameter int VAL_W   = 16,
   localparam int IDX_W  = evt_snap_pkg::idx_bits(NUM_EVT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               emit_valid,
   input  logic [IDX_W-1:0]   emit_idx,
   input  logic [VAL_W-1:0]   emit_val,
   input  logic               snap_strobe,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic               rd_flag,
   output logic [VAL_W-1:0]   rd_val,
   output logic [NUM_EVT-1:0] frz_flags
);
   if (NUM_EVT < 1) begin : g_bad_count
      $error("NUM_EVT must be at least 1");
   end
   if (VAL_W < 1) begin : g_bad_width
      $error("VAL_W must be at least 1");
   end

   logic [NUM_EVT-1:0]       live_flags;
   logic [NUM_EVT*VAL_W-1:0] live_vals;
   logic [NUM_EVT*VAL_W-1:0] frz_vals;

   evt_live_bank #(.NUM_EVT(NUM_EVT), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_live (
      .clk(clk), .rst_n(rst_n), .emit_valid(emit_valid), .emit_idx(emit_idx),
      .emit_val(emit_val), .snap_strobe(snap_strobe),
      .live_flags(live_flags), .live_vals(live_vals));

   evt_frozen_bank #(.NUM_EVT(NUM_EVT), .VAL_W(VAL_W)) u_frozen (
      .clk(clk), .rst_n(rst_n), .snap_strobe(snap_strobe),
      .live_flags(live_flags), .live_vals(live_vals),
      .frz_flags(frz_flags), .frz_vals(frz_vals));

   evt_read_port #(.NUM_EVT(NUM_EVT), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_read (
      .rd_idx(rd_idx), .frz_flags(frz_flags), .frz_vals(frz_vals),
      .rd_flag(rd_flag), .rd_val(rd_val));
endmodule

// File: rtl/evt_snapshot_store_chk.sv
module evt_snapshot_store_chk #(
   parameter int NUM_EVT = 6,
   parameter int VAL_W   = 16,
   parameter int IDX_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               emit_valid,
   input logic [IDX_W-1:0]   emit_idx,
   input logic               snap_strobe,
   input logic [IDX_W-1:0]   rd_idx,
   input logic               rd_flag,
   input logic [VAL_W-1:0]   rd_val,
   input logic [NUM_EVT-1:0] frz_flags,
   input logic [NUM_EVT-1:0] live_flags
);
   logic [NUM_EVT-1:0] emit_hot;
   always_comb begin
      emit_hot = '0;
      for (int i = 0; i < NUM_EVT; i++)
         if (emit_valid && int'(emit_idx) == i) emit_hot[i] = 1'b1;
   end

   a_r2_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_strobe |=> $stable(frz_flags));
   a_r3_copy_live: assert property (@(posedge clk) disable iff (!rst_n)
      snap_strobe |=> frz_flags == $past(live_flags));
   a_r4_live_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_strobe && !emit_valid) |=> live_flags == '0);
   a_r6_emit_sets: assert property (@(posedge clk) disable iff (!rst_n)
      emit_valid |=> (live_flags & $past(emit_hot)) == $past(emit_hot));
   a_r8_oob_read: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_idx) >= NUM_EVT) |-> (!rd_flag && rd_val == '0));
endmodule

bind evt_snapshot_store evt_snapshot_store_chk #(
   .NUM_EVT(NUM_EVT), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .emit_valid(emit_valid), .emit_idx(emit_idx),
   .snap_strobe(snap_strobe), .rd_idx(rd_idx), .rd_flag(rd_flag),
   .rd_val(rd_val), .frz_flags(frz_flags), .live_flags(live_flags));

// File: tb/evt_snapshot_store_bench.sv
`timescale 1ns/100ps
module evt_snapshot_store_bench;
   localparam int  N = 6;
   localparam int  W = 16;
   localparam int  IW = 3;
   localparam real CLK_PERIOD = 10.0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          emit_valid = 1'b0;
   logic [IW-1:0] emit_idx = '0;
   logic [W-1:0]  emit_val = '0;
   logic          snap_strobe = 1'b0;
   logic [IW-1:0] rd_idx = '0;
   logic          rd_flag;
   logic [W-1:0]  rd_val;
   logic [N-1:0]  frz_flags;

   int checks = 0;
   int errors = 0;
   logic         m_lf[N];
   logic [W-1:0] m_lv[N];
   logic         m_ff[N];
   logic [W-1:0] m_fv[N];

   always #(CLK_PERIOD/2) clk = ~clk;

   evt_snapshot_store #(.NUM_EVT(N), .VAL_W(W)) u_evt_snapshot_store (
      .clk(clk), .rst_n(rst_n), .emit_valid(emit_valid), .emit_idx(emit_idx),
      .emit_val(emit_val), .snap_strobe(snap_strobe), .rd_idx(rd_idx),
      .rd_flag(rd_flag), .rd_val(rd_val), .frz_flags(frz_flags));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic exp_flag(input int i);
      return (i < N) ? m_ff[i] : 1'b0;
   endfunction
   function automatic logic [W-1:0] exp_val(input int i);
      return (i < N) ? m_fv[i] : '0;
   endfunction

   task automatic step(input logic ev, input int idx, input logic [W-1:0] v, input logic sn);
      @(negedge clk);
      emit_valid = ev; emit_idx = IW'(idx); emit_val = v; snap_strobe = sn;
      @(posedge clk);
      if (sn) begin
         for (int i = 0; i < N; i++) begin
            m_ff[i] = m_lf[i]; m_fv[i] = m_lv[i]; m_lf[i] = 1'b0;
         end
      end
      if (ev && idx < N) begin
         m_lf[idx] = 1'b1; m_lv[idx] = v;
      end
      #1;
   endtask

   task automatic check_all(input string req);
      logic [N-1:0] fv;
      for (int i = 0; i < (1 << IW); i++) begin
         rd_idx = IW'(i);
         #0.4;
         chk(req, {31'b0, rd_flag}, {31'b0, exp_flag(i)});
         chk(req, {16'b0, rd_val}, {16'b0, exp_val(i)});
      end
      for (int i = 0; i < N; i++) fv[i] = m_ff[i];
      chk(req, {26'b0, frz_flags}, {26'b0, fv});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int r;
      r = $urandom(32'd2024);
      for (int i = 0; i < N; i++) begin
         m_lf[i] = 0; m_lv[i] = 0; m_ff[i] = 0; m_fv[i] = 0;
      end
      repeat (3) @(posedge clk);
      #1 check_all("R1 reset state");
      @(negedge clk) rst_n = 1'b1;

      step(1, 2, 16'hA5A5, 0);
      check_all("R2 emit not visible before strobe");
      step(0, 0, 0, 1);
      check_all("R3 snapshot copy");
      chk("R3 slot2 flag", {31'b0, frz_flags[2]}, 32'd1);
      step(0, 0, 0, 1);
      check_all("R4 live cleared by strobe");
      chk("R7 absent keeps value", {16'b0, m_fv[2]}, 32'hA5A5);

      step(1, 4, 16'h1111, 1);
      check_all("R5 emit at strobe edge excluded");
      step(0, 0, 0, 1);
      check_all("R5 emit at strobe edge in next snapshot");

      step(1, 1, 16'h0001, 0);
      step(1, 1, 16'h0002, 0);
      step(1, 1, 16'h0003, 0);
      step(0, 0, 0, 1);
      check_all("R6 last value kept");
      chk("R6 slot1 value", {16'b0, m_fv[1]}, 32'h0003);

      step(1, 7, 16'hBEEF, 0);
      step(1, 6, 16'hBEEF, 0);
      step(0, 0, 0, 1);
      check_all("R8 out of range emit ignored");

      step(1, 0, 16'h00AA, 0);
      step(1, 3, 16'h00BB, 1);
      chk("R9 x present", {31'b0, frz_flags[0]}, 32'd1);
      chk("R9 y absent", {31'b0, frz_flags[3]}, 32'd0);
      check_all("R9 ordered emits");
      step(0, 0, 0, 1);
      chk("R9 y in later snapshot", {31'b0, frz_flags[3]}, 32'd1);

      for (int c = 0; c < 400; c++) begin
         step(($urandom % 3) != 0, int'($urandom % 8), W'($urandom),
              ($urandom % 6) == 0);
         if (c % 4 == 0) check_all("R3 random mix");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule